// File: doc/BRIEF.md
# APB Register Slave with Error Verdict

This block is an APB completer that owns a small bank of word registers inside a 32-byte window. Every register carries an access kind (read/write, read-only or write-only) and a protection policy checked against PPROT. Several independent checks (unmapped offset, protection mismatch, wrong direction and a fault line from the attached peripheral) are merged into a single verdict. That verdict is returned on PSLVERR in the same cycle that PREADY completes the transfer.

A failed transfer still completes on time. A failed write stores nothing, and a failed read returns all zeros. The reason for the latest failure is kept as a one-hot code in a status register, which software reads and clears with write-1-to-clear. A 2-bit wait setting adds 0 to 3 extra cycles before PREADY rises. The write-only register drives the peripheral directly through a control output.

Top module: `apb_err_slave`

## Requirements
- R1: The word index is PADDR[4:2]. Indices 0 to 4 are mapped and indices 5 to 7 are holes. Any access to a hole ends with PSLVERR high.
- R2: Index 1 requires a privileged access (PPROT[0]=1). Index 3 requires a secure access (PPROT[1]=0). An access that breaks the policy of its register ends with PSLVERR high. PPROT[2] is ignored.
- R3: Index 2 is read-only, so a write to it is an error. Index 3 is write-only, so a read of it is an error. A read of index 2 and a write of index 3 are clean.
- R4: If fault_i is high during the access phase, the transfer ends with PSLVERR high, whichever register is addressed.
- R5: PSLVERR can be high only in a cycle where PREADY is high. It is 0 during setup, during wait cycles and between transfers.
- R6: Count the first cycle with PSEL and PENABLE both high as access cycle 1. With wait_cfg_i = W, PREADY is high in access cycle W+2, for exactly one cycle. This holds whether or not the transfer errors.
- R7: A clean write updates its register: index 0, index 1, or index 3, which is visible on ctrl_o. An errored write leaves every register unchanged.
- R8: A clean read returns the following data. Index 0 and index 1 return the stored value. Index 2 returns the fixed word 0x5EED0002. Index 4 returns the status register in bits [3:0], with the upper bits zero. An errored read returns all zeros.
- R9: The status register at index 4 is updated on every errored completion to a one-hot cause. The bits are: bit0 unmapped, bit1 protection, bit2 direction, bit3 fault. When several causes apply together, only the lowest-numbered bit is set. A clean write to index 4 clears each status bit written as 1. Index 4 has no protection restriction.
- R10: While rst_ni is low, PREADY, PSLVERR, PRDATA, ctrl_o, the stored registers and the status register are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| psel_i | input | 1 | Slave select |
| penable_i | input | 1 | Access phase marker |
| pwrite_i | input | 1 | 1 = write, 0 = read |
| paddr_i | input | 5 | Byte offset within the window |
| pwdata_i | input | 32 | Write data |
| pprot_i | input | 3 | Protection attributes: [0] privileged, [1] non-secure |
| fault_i | input | 1 | Peripheral fault flag |
| wait_cfg_i | input | 2 | Extra wait cycles before completion; change only while idle |
| prdata_o | output | 32 | Read data, registered |
| pready_o | output | 1 | Transfer completion, registered |
| pslverr_o | output | 1 | Error verdict, registered |
| ctrl_o | output | 32 | Value of the write-only register at index 3 |

## Verification
The bound checker watches several timing and consistency rules on every cycle. It confirms that PSLVERR never appears without PREADY and that PREADY is a single-cycle pulse within an access phase. It also confirms that an errored read returns zero data and an errored write leaves ctrl_o steady. Finally, it checks that the cause field holds at most one bit, and exactly one after a failure. The following properties can only be shown by the bench's scenarios: which check fires for each register, protection and direction combination, and the exact wait latency for each setting. The same applies to cause priority when checks overlap, the stored and read-back values, and write-1-to-clear behaviour. The bench sweeps every index, every protection pair, both directions, the fault line and all four wait settings against an arithmetic model.

// File: rtl/apb_err_pkg.sv
package apb_err_pkg;

  typedef enum logic [1:0] {
    KIND_RW = 2'd0,
    KIND_RO = 2'd1,
    KIND_WO = 2'd2
  } acc_kind_e;

  typedef struct packed {
    acc_kind_e kind;
    logic      need_priv;
    logic      need_secure;
  } reg_pol_t;

  // cause bit positions; lower index wins when several apply
  localparam int NUM_CAUSE = 4;
  localparam int C_DEC     = 0;
  localparam int C_PROT    = 1;
  localparam int C_DIR     = 2;
  localparam int C_INT     = 3;

  localparam int CTRL_IDX  = 3;

  function automatic reg_pol_t pol_of(input int unsigned idx);
    reg_pol_t p;
    p.kind        = KIND_RW;
    p.need_priv   = 1'b0;
    p.need_secure = 1'b0;
    case (idx)
      1: p.need_priv = 1'b1;
      2: p.kind      = KIND_RO;
      3: begin
        p.kind        = KIND_WO;
        p.need_secure = 1'b1;
      end
      default: ;
    endcase
    return p;
  endfunction

  function automatic acc_kind_e kind_of(input int unsigned idx);
    reg_pol_t p;
    p = pol_of(idx);
    return p.kind;
  endfunction

endpackage

// File: rtl/apb_err_check.sv
module apb_err_check
  import apb_err_pkg::*;
#(
  parameter int NUM_REGS = 5,
  parameter int IDX_W    = 3
) (
  input  logic                 access_i,
  input  logic                 pwrite_i,
  input  logic [IDX_W-1:0]     idx_i,
  input  logic [1:0]           prot_i,
  input  logic                 fault_i,
  output logic [NUM_REGS-1:0]  hit_o,
  output logic [NUM_CAUSE-1:0] cause_o,
  output logic                 err_o
);

  logic                 dec_e, prot_e, dir_e;
  logic [NUM_CAUSE-1:0] raw;
  reg_pol_t             pol;

  always_comb begin
    hit_o  = '0;
    dec_e  = 1'b1;
    prot_e = 1'b0;
    dir_e  = 1'b0;
    pol    = pol_of(0);
    for (int i = 0; i < NUM_REGS; i++) begin
      if (idx_i == IDX_W'(i)) begin
        hit_o[i] = 1'b1;
        dec_e    = 1'b0;
        pol      = pol_of(unsigned'(i));
        prot_e   = (pol.need_priv & ~prot_i[0]) | (pol.need_secure & prot_i[1]);
        dir_e    = ((pol.kind == KIND_RO) &  pwrite_i) |
                   ((pol.kind == KIND_WO) & ~pwrite_i);
      end
    end
  end

  always_comb begin
    raw          = '0;
    raw[C_DEC]   = dec_e;
    raw[C_PROT]  = prot_e;
    raw[C_DIR]   = dir_e;
    raw[C_INT]   = fault_i;
    raw          = raw & {NUM_CAUSE{access_i}};
  end

  assign err_o   = |raw;
  // isolate lowest set bit
  assign cause_o = raw & (~raw + NUM_CAUSE'(1));

endmodule

// File: rtl/apb_err_timer.sv
module apb_err_timer #(
  parameter int WAIT_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              access_i,
  input  logic [WAIT_W-1:0] wait_i,
  output logic              complete_o,
  output logic              pready_o
);

  logic [WAIT_W-1:0] cnt_q;
  logic              ready_q;

  assign complete_o = access_i & ~ready_q & (cnt_q >= wait_i);
  assign pready_o   = ready_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      ready_q <= 1'b0;
    end else begin
      ready_q <= complete_o;
      if (!access_i || ready_q) cnt_q <= '0;
      else if (!complete_o)     cnt_q <= cnt_q + WAIT_W'(1);
    end
  end

endmodule

// File: rtl/apb_err_verdict.sv
module apb_err_verdict
  import apb_err_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 complete_i,
  input  logic                 err_i,
  input  logic [NUM_CAUSE-1:0] cause_i,
  input  logic                 wr_raw_i,
  input  logic                 stat_hit_i,
  input  logic [NUM_CAUSE-1:0] clr_mask_i,
  output logic                 commit_o,
  output logic                 pslverr_o,
  output logic [NUM_CAUSE-1:0] status_o
);

  logic                 err_q;
  logic [NUM_CAUSE-1:0] stat_q;

  assign commit_o  = wr_raw_i & ~err_i;
  assign pslverr_o = err_q;
  assign status_o  = stat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else         err_q <= complete_i & err_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   stat_q <= '0;
    else if (complete_i && err_i)  stat_q <= cause_i;
    else if (commit_o && stat_hit_i) stat_q <= stat_q & ~clr_mask_i;
  end

endmodule

// File: rtl/apb_err_regs.sv
module apb_err_regs
  import apb_err_pkg::*;
#(
  parameter int              DATA_W   = 32,
  parameter int              NUM_REGS = 5,
  parameter logic [DATA_W-1:0] ID_VALUE = 32'h5EED_0002
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_REGS-1:0]  we_i,
  input  logic [NUM_REGS-1:0]  rd_hit_i,
  input  logic [DATA_W-1:0]    wdata_i,
  input  logic [NUM_CAUSE-1:0] status_i,
  output logic [DATA_W-1:0]    rdata_o,
  output logic [DATA_W-1:0]    ctrl_o
);

  logic [DATA_W-1:0] word [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    localparam acc_kind_e KIND = kind_of(g);
    if (g == NUM_REGS - 1) begin : g_stat
      logic unused_we;
      assign unused_we = we_i[g];
      assign word[g]   = DATA_W'(status_i);
    end else if (KIND == KIND_RO) begin : g_ro
      logic unused_we;
      assign unused_we = we_i[g];
      assign word[g]   = ID_VALUE;
    end else begin : g_rw
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     q <= '0;
        else if (we_i[g]) q <= wdata_i;
      end
      assign word[g] = q;
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (rd_hit_i[i]) rdata_o = rdata_o | word[i];
  end

  assign ctrl_o = word[CTRL_IDX];

endmodule

// File: rtl/apb_err_slave.sv
module apb_err_slave
  import apb_err_pkg::*;
#(
  parameter int                DATA_W   = 32,
  parameter int                ADDR_W   = 5,
  parameter int                NUM_REGS = 5,
  parameter int                WAIT_W   = 2,
  parameter logic [DATA_W-1:0] ID_VALUE = 32'h5EED_0002
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              psel_i,
  input  logic              penable_i,
  input  logic              pwrite_i,
  input  logic [ADDR_W-1:0] paddr_i,
  input  logic [DATA_W-1:0] pwdata_i,
  input  logic [2:0]        pprot_i,
  input  logic              fault_i,
  input  logic [WAIT_W-1:0] wait_cfg_i,
  output logic [DATA_W-1:0] prdata_o,
  output logic              pready_o,
  output logic              pslverr_o,
  output logic [DATA_W-1:0] ctrl_o
);

  localparam int IDX_W    = ADDR_W - 2;
  localparam int STAT_IDX = NUM_REGS - 1;

  logic                 access;
  logic                 complete;
  logic                 err;
  logic                 commit;
  logic [NUM_REGS-1:0]  hit;
  logic [NUM_CAUSE-1:0] cause;
  logic [NUM_CAUSE-1:0] status_q;
  logic [DATA_W-1:0]    rdata;
  logic [DATA_W-1:0]    prdata_q;
  logic                 unused_bits;

  assign access      = psel_i & penable_i;
  assign unused_bits = ^{paddr_i[1:0], pprot_i[2]};

  apb_err_check #(
    .NUM_REGS (NUM_REGS),
    .IDX_W    (IDX_W)
  ) check_i (
    .access_i (access),
    .pwrite_i (pwrite_i),
    .idx_i    (paddr_i[ADDR_W-1:2]),
    .prot_i   (pprot_i[1:0]),
    .fault_i  (fault_i),
    .hit_o    (hit),
    .cause_o  (cause),
    .err_o    (err)
  );

  apb_err_timer #(
    .WAIT_W (WAIT_W)
  ) timer_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .access_i   (access),
    .wait_i     (wait_cfg_i),
    .complete_o (complete),
    .pready_o   (pready_o)
  );

  apb_err_verdict verdict_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .complete_i (complete),
    .err_i      (err),
    .cause_i    (cause),
    .wr_raw_i   (complete & pwrite_i),
    .stat_hit_i (hit[STAT_IDX]),
    .clr_mask_i (pwdata_i[NUM_CAUSE-1:0]),
    .commit_o   (commit),
    .pslverr_o  (pslverr_o),
    .status_o   (status_q)
  );

  apb_err_regs #(
    .DATA_W   (DATA_W),
    .NUM_REGS (NUM_REGS),
    .ID_VALUE (ID_VALUE)
  ) regs_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (hit & {NUM_REGS{commit}}),
    .rd_hit_i (hit),
    .wdata_i  (pwdata_i),
    .status_i (status_q),
    .rdata_o  (rdata),
    .ctrl_o   (ctrl_o)
  );

  // read data only on a clean read completion, zero otherwise
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          prdata_q <= '0;
    else if (complete && !pwrite_i && !err) prdata_q <= rdata;
    else                                  prdata_q <= '0;
  end

  assign prdata_o = prdata_q;

endmodule

// File: rtl/apb_err_slave_chk.sv
module apb_err_slave_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              psel_i,
  input logic              penable_i,
  input logic              pwrite_i,
  input logic              pready_i,
  input logic              pslverr_i,
  input logic [DATA_W-1:0] prdata_i,
  input logic [DATA_W-1:0] ctrl_i,
  input logic [3:0]        status_i
);

  p_err_with_ready_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pslverr_i |-> pready_i);

  p_ready_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pready_i |=> !pready_i);

  p_ready_in_access_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pready_i |-> (psel_i && penable_i));

  p_err_no_store_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pslverr_i && pwrite_i) |-> $stable(ctrl_i));

  p_err_rd_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pslverr_i && !pwrite_i) |-> (prdata_i == '0));

  p_stat_onehot_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(status_i));

  p_err_cause_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pslverr_i |-> ($countones(status_i) == 1));

endmodule

bind apb_err_slave apb_err_slave_chk #(.DATA_W(DATA_W)) chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .psel_i    (psel_i),
  .penable_i (penable_i),
  .pwrite_i  (pwrite_i),
  .pready_i  (pready_o),
  .pslverr_i (pslverr_o),
  .prdata_i  (prdata_o),
  .ctrl_i    (ctrl_o),
  .status_i  (status_q)
);

// File: tb/apb_err_slave_tb_top.sv
`timescale 1ns/1ps
module apb_err_slave_tb_top;

  localparam logic [31:0] ID_WORD = 32'h5EED_0002;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0, fault = 1'b0;
  logic [4:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [2:0]  pprot = '0;
  logic [1:0]  wait_cfg = '0;
  logic [31:0] prdata, ctrl;
  logic        pready, pslverr;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [31:0] m0 = '0, m1 = '0, m3 = '0;
  logic [3:0]  mstat = '0;

  always #4 clk = ~clk;

  apb_err_slave dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .psel_i     (psel),
    .penable_i  (penable),
    .pwrite_i   (pwrite),
    .paddr_i    (paddr),
    .pwdata_i   (pwdata),
    .pprot_i    (pprot),
    .fault_i    (fault),
    .wait_cfg_i (wait_cfg),
    .prdata_o   (prdata),
    .pready_o   (pready),
    .pslverr_o  (pslverr),
    .ctrl_o     (ctrl)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  function automatic logic [3:0] exp_cause(input int idx, input bit wr,
                                           input logic [1:0] prot, input bit flt);
    if (idx > 4) return 4'b0001;
    if ((idx == 1 && !prot[0]) || (idx == 3 && prot[1])) return 4'b0010;
    if ((idx == 2 && wr) || (idx == 3 && !wr)) return 4'b0100;
    if (flt) return 4'b1000;
    return 4'b0000;
  endfunction

  function automatic string tag_of(input logic [3:0] c);
    case (c)
      4'b0001: return "R1 unmapped";
      4'b0010: return "R2 protection";
      4'b0100: return "R3 direction";
      4'b1000: return "R4 fault";
      default: return "R3 clean access";
    endcase
  endfunction

  task automatic xfer(input int idx, input bit wr, input logic [1:0] prot,
                      input bit flt, input logic [31:0] wd, input int w);
    logic [3:0]  c;
    logic [31:0] exp_rd;
    int          n;
    c = exp_cause(idx, wr, prot, flt);
    exp_rd = '0;
    if (c == 0 && !wr) begin
      case (idx)
        0: exp_rd = m0;
        1: exp_rd = m1;
        2: exp_rd = ID_WORD;
        4: exp_rd = {28'b0, mstat};
        default: exp_rd = '0;
      endcase
    end
    @(negedge clk);
    wait_cfg = 2'(w);
    psel = 1'b1; penable = 1'b0; pwrite = wr;
    paddr = {3'(idx), 2'b00}; pwdata = wd; pprot = {1'b1, prot}; fault = flt;
    check(!pready && !pslverr, "R5 idle before access", {30'b0, pready, pslverr}, 0);
    @(negedge clk);
    penable = 1'b1;
    n = 0;
    do begin
      @(negedge clk);
      n++;
      if (!pready && n > 1)
        check(!pslverr, "R5 no verdict in wait", {31'b0, pslverr}, 0);
    end while (!pready && n < 12);
    check(n == w + 1, "R6 completion latency", n, w + 1);
    check(pslverr == (c != 0), tag_of(c), {31'b0, pslverr}, {31'b0, (c != 0)});
    if (!wr) check(prdata == exp_rd, "R8 read data", prdata, exp_rd);
    if (c != 0) mstat = c;
    else if (wr) begin
      case (idx)
        0: m0 = wd;
        1: m1 = wd;
        3: m3 = wd;
        4: mstat = mstat & ~wd[3:0];
        default: ;
      endcase
    end
    if (wr) check(ctrl == m3, "R7 control register", ctrl, m3);
    @(negedge clk);
    check(!pready && !pslverr, "R5 one cycle only", {30'b0, pready, pslverr}, 0);
    psel = 1'b0; penable = 1'b0; fault = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    int k;
    repeat (3) @(negedge clk);
    // R10: reset state
    check(!pready && !pslverr, "R10 reset handshake", {30'b0, pready, pslverr}, 0);
    check(prdata == 0 && ctrl == 0, "R10 reset data", prdata | ctrl, 0);
    rst_n = 1'b1;
    xfer(4, 0, 2'b00, 0, 0, 0);
    xfer(0, 0, 2'b00, 0, 0, 0);
    xfer(1, 0, 2'b01, 0, 0, 1);

    // sweep: waits x indices x prot x direction x fault
    k = 0;
    for (int w = 0; w < 4; w++)
      for (int idx = 0; idx < 8; idx++)
        for (int p = 0; p < 4; p++)
          for (int wr = 0; wr < 2; wr++)
            for (int f = 0; f < 2; f++) begin
              k++;
              xfer(idx, wr[0], 2'(p), f[0],
                   {8'(idx), 8'(p), 8'(w), 8'(k)} ^ 32'hA5C3_0000, w);
              xfer(4, 0, 2'b00, 0, 0, 0);
              xfer(0, 0, 2'b01, 0, 0, 0);
              xfer(1, 0, 2'b11, 0, 0, 0);
            end

    // R9: priority and write-1-to-clear
    xfer(3, 0, 2'b10, 1, 0, 2);
    xfer(4, 0, 2'b00, 0, 0, 0);
    check(mstat == 4'b0010, "R9 priority protection over direction and fault",
          {28'b0, mstat}, 32'h2);
    xfer(0, 1, 2'b00, 1, 32'h1234, 0);
    xfer(4, 1, 2'b00, 0, 32'h0, 0);
    xfer(4, 0, 2'b00, 0, 0, 0);
    xfer(4, 1, 2'b11, 0, 32'h8, 3);
    xfer(4, 0, 2'b00, 0, 0, 0);
    check(mstat == 0, "R9 write-1-to-clear", {28'b0, mstat}, 0);
    report();
  end

endmodule